// File: doc/BRIEF.md
# Digit-Parallel Carry-Less Polynomial Multiplier

This block multiplies two binary polynomials over GF(2), 233 coefficients each, and returns the full 465-coefficient product without modular reduction. Reduction is left to a separate stage further down the datapath. The multiplier operand is cut into 32-bit digits, starting at the least significant end. Each digit is multiplied against the whole multiplicand in its own combinational slice. The slice results are shifted to their digit position and folded together with XOR. A single output register captures the result, so one product costs exactly one clock cycle.

A field arithmetic unit uses the block by presenting both operands with a one-cycle start strobe. On the next cycle, done is high for one cycle and the product is on the output. The product register then keeps that value until a later start replaces it. Starts may be issued on consecutive cycles. Each start yields its own product one cycle later.

Top module: `dp_gf2_mul`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, done is 0 and product is all zero.
- R2: done is 1 in exactly the cycle after a cycle with start high, and 0 in every other cycle.
- R3: When done is 1, product bit k (0 to 464) equals the XOR over all pairs i+j=k of op_a[i] AND op_b[j], sampled in the start cycle. This is the carry-less product of the two operands.
- R4: Starts on consecutive cycles each deliver their own product, in the cycle after their own start.
- R5: While start is low, product keeps its last value, and changes on op_a or op_b have no effect on it.
- R6: op_b is handled as eight 32-bit digits, with digit 0 holding bits 31:0. The top digit holds only bits 232:224, and its missing upper bits count as zero. Operands whose set bits lie only in that top digit give the correct carry-less product.
- R7: If either operand is all zero, the product is all zero.
- R8: Product bit 464 equals op_a[232] AND op_b[232]. Product bit 0 equals op_a[0] AND op_b[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to multiply the present operands |
| op_a | input | 233 | Multiplicand polynomial, bit i is the coefficient of x^i |
| op_b | input | 233 | Multiplier polynomial, cut into 32-bit digits |
| done | output | 1 | High in the cycle after start |
| product | output | 465 | Unreduced carry-less product |

## Verification
The assertions assume that op_a and op_b are stable and known in every cycle where start is high. They also assume start is low while reset is active, so that the first sample after reset refers to an idle cycle. The stimulus drives start and the operands only on the falling edge. It holds start low through reset. It gives the operands known values before the first start. Between requests, the operands are scrambled only while start is low, which tests that they are ignored at those times.

// File: rtl/gf2_dp_pkg.sv
package gf2_dp_pkg;

  // Number of whole digits needed to cover a given width.
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dp_digit_slice.sv
// One digit of the multiplier operand times the full multiplicand.
module dp_digit_slice #(
  parameter int unsigned AW = 233,
  parameter int unsigned DW = 32,
  localparam int unsigned PPW = AW + DW - 1
) (
  input  logic [AW-1:0]  mcand,
  input  logic [DW-1:0]  digit,
  output logic [PPW-1:0] partial
);

  always_comb begin
    partial = '0;
    for (int j = 0; j < DW; j++) begin
      if (digit[j]) begin
        partial = partial ^ (PPW'(mcand) << j);
      end
    end
  end

endmodule

// File: rtl/dp_shift_accum.sv
// Aligns every partial product to its digit position and XOR-folds them.
module dp_shift_accum #(
  parameter int unsigned AW = 233,
  parameter int unsigned DW = 32,
  parameter int unsigned ND = 8,
  localparam int unsigned PPW = AW + DW - 1,
  localparam int unsigned WW  = ND * DW + AW - 1
) (
  input  logic [ND-1:0][PPW-1:0] partials,
  output logic [WW-1:0]          folded
);

  always_comb begin
    folded = '0;
    for (int i = 0; i < ND; i++) begin
      folded = folded ^ (WW'(partials[i]) << (i * DW));
    end
  end

endmodule

// File: rtl/dp_gf2_mul.sv
module dp_gf2_mul
  import gf2_dp_pkg::*;
#(
  parameter int unsigned AW = 233,
  parameter int unsigned DW = 32,
  localparam int unsigned PW  = 2 * AW - 1,
  localparam int unsigned ND  = ceil_div(AW, DW),
  localparam int unsigned BPW = ND * DW,
  localparam int unsigned PPW = AW + DW - 1,
  localparam int unsigned WW  = BPW + AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_b,
  output logic          done,
  output logic [PW-1:0] product
);

  // Multiplier operand padded to a whole number of digits (top digit zero-filled).
  logic [BPW-1:0]         b_padded;
  logic [ND-1:0][PPW-1:0] partials;
  logic [WW-1:0]          folded;

  always_comb begin
    b_padded          = '0;
    b_padded[AW-1:0]  = op_b;
  end

  for (genvar g = 0; g < ND; g++) begin : g_slice
    dp_digit_slice #(.AW(AW), .DW(DW)) u_slice (
      .mcand   (op_a),
      .digit   (b_padded[g*DW +: DW]),
      .partial (partials[g])
    );
  end

  dp_shift_accum #(.AW(AW), .DW(DW), .ND(ND)) u_accum (
    .partials (partials),
    .folded   (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= start;
      if (start) begin
        product <= folded[PW-1:0];
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done);                                                     // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);                                                   // R2
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(product));                                        // R5
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (start && (op_a == '0 || op_b == '0)) |=> (product == '0));          // R7
  AST_LOW_COEF: assert property (@(posedge clk) disable iff (rst)
    start |=> (product[0] == ($past(op_a[0]) & $past(op_b[0]))));        // R8
  AST_TOP_COEF: assert property (@(posedge clk) disable iff (rst)
    start |=> (product[PW-1] == ($past(op_a[AW-1]) & $past(op_b[AW-1])))); // R8

  if (WW > PW) begin : g_pad_chk
    AST_PAD_DIGIT_EMPTY: assert property (@(posedge clk) disable iff (rst)
      start |-> (folded[WW-1:PW] == '0));                                // R6
  end

endmodule

// File: tb/dp_gf2_mul_tb.sv
module dp_gf2_mul_tb;

  localparam int AW = 233;
  localparam int PW = 2 * AW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] op_a = '0;
  logic [AW-1:0] op_b = '0;
  logic          done;
  logic [PW-1:0] product;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] last_exp = '0;

  always #2.5 clk = ~clk;

  dp_gf2_mul u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .done(done), .product(product)
  );

  function automatic logic [PW-1:0] ref_clmul(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < AW; i++)
      for (int j = 0; j < AW; j++)
        r[i+j] = r[i+j] ^ (a[i] & b[j]);
    return r;
  endfunction

  function automatic logic [AW-1:0] rand_op();
    logic [AW-1:0] v = '0;
    for (int k = 0; k < AW; k += 32) v = (v << 32) | AW'($urandom());
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [AW-1:0] b, input string tag);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    exp_q.push_back(ref_clmul(a, b));
    tag_q.push_back(tag);
  endtask

  // Idle with scrambled operands; product must hold the last result (R5).
  task automatic idle_hold(input int n);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(product == last_exp && !done, "R5 hold", product, last_exp);
      op_a = rand_op();
      op_b = rand_op();
    end
  endtask

  // Monitor: scoreboard pop and compare when done appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 done without start", PW'(done), '0);
        end else begin
          logic [PW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(product == e, t, product, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 during reset", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 after reset", product, '0);

    issue('0, rand_op(), "R7 zero a");
    issue(rand_op(), '0, "R7 zero b");
    issue(ones, ones, "R8 all ones");
    issue(AW'(1), AW'(1), "R8 unit times unit");
    issue(AW'(1) << (AW-1), AW'(1) << (AW-1), "R8 top bits");
    idle_hold(4);

    issue(rand_op(), AW'(1) << 224, "R6 top digit lowest bit");
    issue(rand_op(), ones & ~((AW'(1) << 224) - 1), "R6 top digit full");
    issue(ones, AW'(1) << 31, "R6 digit edge 31");
    issue(ones, AW'(1) << 32, "R6 digit edge 32");
    idle_hold(3);

    for (int i = 0; i < 20; i++) issue(rand_op(), rand_op(), "R4 back to back");
    idle_hold(3);

    for (int i = 0; i < 16; i++) begin
      issue(rand_op(), rand_op(), "R3 random");
      @(negedge clk);
      start = 1'b0;
    end
    idle_hold(3);

    for (int i = 0; i < 8; i++) begin
      issue(AW'(1) << ($urandom() % AW), AW'(1) << ($urandom() % AW), "R3 single bit");
    end
    idle_hold(4);

    check(exp_q.size() == 0, "R2 missing done", PW'(exp_q.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule